// File: doc/BRIEF.md
# Phase-Synchronized PWM Channel with Skipped-Edge Recovery

This block is one channel of a phase-shifted PWM generator. A counter runs upward from zero to a programmed terminal count and wraps back to zero. The output goes high when the count becomes zero and goes low when the count becomes equal to the active compare value. A slave channel, with phase loading enabled, is locked to a master by a sync pulse. Each sync pulse overwrites the count with a programmable phase value. Software may change the phase every cycle, and in phase-shifted power converters it often jumps by a large step.

A large phase step can carry the counter straight past the compare point or past zero. When that happens, the clear or set edge for that cycle is lost. To restore the missing edge, a sync-triggered action can set the output, clear it, or leave it alone on the sync cycle itself. A software force can also drive the output to a chosen level. When several of these events land on the same clock, a fixed priority decides the result. The compare value is normally shadowed and taken on at counter zero, and an immediate mode can be selected instead. With phase loading disabled, the channel acts as a master and emits a sync pulse at each counter zero.

Top module: `pwm_phase_sync`

## Requirements
- R1: After reset, `count_out` is 0 and `pwm_out` is 0. Without a phase load, the count steps up by one per clock. In the clock after the count has reached `period_in` (or any larger value), the count becomes 0.
- R2: The output is set in the clock where the count becomes 0. It is cleared in the clock where the count becomes equal to the active compare value. Both events are judged on the new count, so the output changes in the same clock as `count_out`.
- R3: When `phase_en` is 1 and `sync_in` is 1 at a clock edge, that edge loads `phase_in` into the count in place of the normal step. When `phase_en` is 0, `sync_in` has no effect on the count.
- R4: If a phase load carries the count from below the compare value to above it, no clear happens in that period unless a sync action supplies one. Likewise, a load that skips zero produces no set.
- R5: `sync_act` selects the output action on a phase-load clock: 2'b00 does nothing, 2'b01 clears, 2'b10 sets, and 2'b11 does nothing. It is read in the same clock it is presented, with no shadow stage.
- R6: With `cmp_imm` at 0, a new `cmp_in` value is taken on only at the clock where the count becomes 0. With `cmp_imm` at 1, it becomes active one clock after it is presented.
- R7: A compare match is judged on the count after any phase load. A load of a phase equal to the active compare value therefore clears the output.
- R8: When events coincide, one action wins, in this order: software force, then sync action, then compare match, then zero match. `force_act` uses the same encoding as `sync_act`. A source whose action is "nothing" does not take part.
- R9: With `phase_en` at 0, `sync_out` is high for exactly the clocks in which `count_out` has just become 0 from the count logic. With `phase_en` at 1, `sync_out` follows `sync_in` combinationally.
- R10: When phase steps move between values near the compare point and values near zero, and the sync action is chosen to restore any skipped level, each sync interval holds exactly one rising and one falling edge, not counting the edge on the sync clock itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Sync pulse from the master channel |
| phase_en | input | 1 | 1: slave, loads phase on sync; 0: master |
| period_in | input | CNT_W | Terminal count (cycle length minus one) |
| phase_in | input | CNT_W | Count value loaded on sync |
| cmp_in | input | CNT_W | Compare value written by software |
| cmp_imm | input | 1 | 1: compare written straight to the active register |
| sync_act | input | 2 | Output action on sync (00 none, 01 clear, 10 set, 11 none) |
| force_req | input | 1 | Software force request, acts on this clock |
| force_act | input | 2 | Forced action, same encoding as sync_act |
| pwm_out | output | 1 | PWM output |
| sync_out | output | 1 | Sync pulse to downstream channels |
| count_out | output | CNT_W | Current counter value |

## Verification
The risky coincidences are a phase load landing on the compare value or on zero while a sync action is also armed, and a software force arriving in the clock where the counter meets the compare value or wraps to zero. The bench provokes these by firing sync at chosen counts with phase equal to the compare value or to zero, with and without a sync action. It also pulses the force one clock before a compare match, during a sync, and at the wrap. In each case it judges the output in the very next clock against the level the priority order dictates. A run of phase steps then counts rising and falling edges per sync interval to show that no pulse is lost when the recovery action is used, and that one is lost when it is not.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_RSVD = 2'b11
    } act_e;

    typedef struct packed {
        logic sync_hit;
        logic cmp_hit;
        logic zero_hit;
    } evt_t;

    // action sources, index 0 is the strongest
    localparam int NUM_SRC   = 4;
    localparam int SRC_FORCE = 0;
    localparam int SRC_SYNC  = 1;
    localparam int SRC_CMP   = 2;
    localparam int SRC_ZERO  = 3;

    function automatic logic act_live(act_e a);
        return (a == ACT_LOW) || (a == ACT_HIGH);
    endfunction

    function automatic logic act_apply(act_e a, logic cur);
        case (a)
            ACT_LOW:  return 1'b0;
            ACT_HIGH: return 1'b1;
            default:  return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic             phase_en,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] phase_in,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             sync_hit,
    output logic             zero_hit,
    output logic             sync_out
);
    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    logic mst_pulse_q;

    always_comb begin
        sync_hit = phase_en & sync_in;
        if (sync_hit)
            cnt_nxt = phase_in;
        else if (cnt_q >= period_in)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_q + STEP;
        zero_hit = (cnt_nxt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            mst_pulse_q <= 1'b0;
        end else begin
            cnt_q       <= cnt_nxt;
            mst_pulse_q <= zero_hit & ~phase_en;
        end
    end

    assign sync_out = phase_en ? sync_in : mst_pulse_q;

endmodule

// File: rtl/pwm_cmp_hold.sv
module pwm_cmp_hold #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             imm_mode,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic             zero_hit,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] cmp_act,
    output logic             cmp_hit
);
    // match is judged on the count being loaded, against the value active now
    assign cmp_hit = (cnt_nxt == cmp_act);

    always_ff @(posedge clk) begin
        if (rst)
            cmp_act <= '0;
        else if (imm_mode || zero_hit)
            cmp_act <= cmp_in;
    end

endmodule

// File: rtl/pwm_act_qual.sv
module pwm_act_qual
    import pwm_sync_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic force_req,
    input  act_e force_act,
    input  act_e sync_act,
    input  evt_t evt,
    output logic pwm_q
);
    act_e src  [NUM_SRC];
    logic live [NUM_SRC];
    act_e win;
    logic pwm_nxt;

    always_comb begin
        src[SRC_FORCE]  = force_act;
        live[SRC_FORCE] = force_req & act_live(force_act);
        src[SRC_SYNC]   = sync_act;
        live[SRC_SYNC]  = evt.sync_hit & act_live(sync_act);
        src[SRC_CMP]    = ACT_LOW;
        live[SRC_CMP]   = evt.cmp_hit;
        src[SRC_ZERO]   = ACT_HIGH;
        live[SRC_ZERO]  = evt.zero_hit;
    end

    // walk from weakest to strongest so the strongest live source remains
    always_comb begin
        win = ACT_NONE;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (live[i])
                win = src[i];
        end
        pwm_nxt = act_apply(win, pwm_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            pwm_q <= 1'b0;
        else
            pwm_q <= pwm_nxt;
    end

endmodule

// File: rtl/pwm_phase_sync.sv
module pwm_phase_sync
    import pwm_sync_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic             phase_en,
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] phase_in,
    input  logic [CNT_W-1:0] cmp_in,
    input  logic             cmp_imm,
    input  logic [1:0]       sync_act,
    input  logic             force_req,
    input  logic [1:0]       force_act,
    output logic             pwm_out,
    output logic             sync_out,
    output logic [CNT_W-1:0] count_out
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic [CNT_W-1:0] cmp_act;
    evt_t             evt;

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .phase_en  (phase_en),
        .period_in (period_in),
        .phase_in  (phase_in),
        .cnt_q     (cnt_q),
        .cnt_nxt   (cnt_nxt),
        .sync_hit  (evt.sync_hit),
        .zero_hit  (evt.zero_hit),
        .sync_out  (sync_out)
    );

    pwm_cmp_hold #(.CNT_W(CNT_W)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .imm_mode (cmp_imm),
        .cmp_in   (cmp_in),
        .zero_hit (evt.zero_hit),
        .cnt_nxt  (cnt_nxt),
        .cmp_act  (cmp_act),
        .cmp_hit  (evt.cmp_hit)
    );

    pwm_act_qual u_aq (
        .clk       (clk),
        .rst       (rst),
        .force_req (force_req),
        .force_act (act_e'(force_act)),
        .sync_act  (act_e'(sync_act)),
        .evt       (evt),
        .pwm_q     (pwm_out)
    );

    assign count_out = cnt_q;

endmodule

// File: rtl/pwm_phase_sync_chk.sv
module pwm_phase_sync_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_in,
    input logic             phase_en,
    input logic [CNT_W-1:0] period_in,
    input logic [CNT_W-1:0] phase_in,
    input logic [1:0]       sync_act,
    input logic             force_req,
    input logic [1:0]       force_act,
    input logic             pwm_out,
    input logic             sync_out,
    input logic [CNT_W-1:0] count_out
);
    logic force_live;
    assign force_live = force_req && (force_act == 2'b01 || force_act == 2'b10);

    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (!(phase_en && sync_in) && count_out >= period_in) |=> (count_out == '0));

    assert_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!(phase_en && sync_in) && count_out < period_in)
        |=> (count_out == $past(count_out) + CNT_W'(1)));

    assert_phase_load_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sync_in) |=> (count_out == $past(phase_in)));

    assert_sync_set_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sync_in && sync_act == 2'b10 && !force_live) |=> pwm_out);

    assert_sync_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_en && sync_in && sync_act == 2'b01 && !force_live) |=> !pwm_out);

    assert_force_high_R8: assert property (@(posedge clk) disable iff (rst)
        (force_req && force_act == 2'b10) |=> pwm_out);

    assert_force_low_R8: assert property (@(posedge clk) disable iff (rst)
        (force_req && force_act == 2'b01) |=> !pwm_out);

    assert_slave_pass_R9: assert property (@(posedge clk) disable iff (rst)
        phase_en |-> (sync_out == sync_in));

    assert_master_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (!phase_en && sync_out) |-> (count_out == '0));

endmodule

bind pwm_phase_sync pwm_phase_sync_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_in   (sync_in),
    .phase_en  (phase_en),
    .period_in (period_in),
    .phase_in  (phase_in),
    .sync_act  (sync_act),
    .force_req (force_req),
    .force_act (force_act),
    .pwm_out   (pwm_out),
    .sync_out  (sync_out),
    .count_out (count_out)
);

// File: tb/tb_pwm_phase_sync.sv
`timescale 1ns/1ps
module tb_pwm_phase_sync;
    localparam int W   = 16;
    localparam int PER = 99;
    localparam int CMP = 50;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sync_in = 1'b0;
    logic         phase_en = 1'b0;
    logic [W-1:0] period_in = W'(PER);
    logic [W-1:0] phase_in = '0;
    logic [W-1:0] cmp_in = W'(CMP);
    logic         cmp_imm = 1'b0;
    logic [1:0]   sync_act = 2'b00;
    logic         force_req = 1'b0;
    logic [1:0]   force_act = 2'b00;
    logic         pwm_out;
    logic         sync_out;
    logic [W-1:0] count_out;

    int    n_checks = 0;
    int    n_errors = 0;
    logic  chk_on = 1'b0;
    logic  done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    pwm_phase_sync #(.CNT_W(W)) dut (
        .clk(clk), .rst(rst), .sync_in(sync_in), .phase_en(phase_en),
        .period_in(period_in), .phase_in(phase_in), .cmp_in(cmp_in),
        .cmp_imm(cmp_imm), .sync_act(sync_act), .force_req(force_req),
        .force_act(force_act), .pwm_out(pwm_out), .sync_out(sync_out),
        .count_out(count_out)
    );

    task automatic chk(input string tag, input int got, input int exp, input string what);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // behavioural reference built from the requirements
    logic [W-1:0] m_cnt, m_cact, m_n;
    logic         m_out, m_mst, m_sh;
    logic [1:0]   m_w;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = '0; m_out = 1'b0; m_cact = '0; m_mst = 1'b0;
        end else begin
            m_sh = phase_en && sync_in;
            m_n  = m_sh ? phase_in : ((m_cnt >= period_in) ? '0 : m_cnt + W'(1));
            m_w  = 2'b00;
            if (force_req && (force_act == 2'b01 || force_act == 2'b10)) m_w = force_act;
            else if (m_sh && (sync_act == 2'b01 || sync_act == 2'b10))   m_w = sync_act;
            else if (m_n == m_cact)                                       m_w = 2'b01;
            else if (m_n == '0)                                           m_w = 2'b10;
            if (m_w == 2'b01) m_out = 1'b0;
            else if (m_w == 2'b10) m_out = 1'b1;
            m_mst = (m_n == '0) && !phase_en;
            if (cmp_imm || m_n == '0) m_cact = cmp_in;
            m_cnt = m_n;
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            chk(cur_req, int'(pwm_out), int'(m_out), "pwm_out vs reference");
            chk(cur_req, int'(count_out), int'(m_cnt), "count_out vs reference");
            chk(cur_req, int'(sync_out), int'(phase_en ? sync_in : m_mst), "sync_out vs reference");
        end
    end

    task automatic wait_cnt(input int s);
        do @(negedge clk); while (int'(count_out) != s);
    endtask

    // {sync count[18:11], phase[10:3], sync action[2:1], expected output[0]}
    localparam int NVEC = 10;
    localparam logic [18:0] VEC [NVEC] = '{
        {8'd30, 8'd70, 2'b00, 1'b1},
        {8'd30, 8'd70, 2'b01, 1'b0},
        {8'd60, 8'd10, 2'b00, 1'b0},
        {8'd60, 8'd10, 2'b10, 1'b1},
        {8'd30, 8'd50, 2'b00, 1'b0},
        {8'd30, 8'd50, 2'b10, 1'b1},
        {8'd60, 8'd0,  2'b01, 1'b0},
        {8'd60, 8'd0,  2'b00, 1'b1},
        {8'd45, 8'd48, 2'b00, 1'b1},
        {8'd60, 8'd10, 2'b11, 1'b0}
    };

    function automatic string vtag(input int i);
        case (i)
            0, 2:    return "R4";
            1, 3, 9: return "R5";
            4:       return "R7";
            5, 6:    return "R8";
            default: return "R2";
        endcase
    endfunction

    // one sync interval of 100 clocks; call at a falling edge
    task automatic step_iv(input int p, input logic fix, input logic judge,
                           input int exp_r, input string tag);
        logic v, t, prev;
        logic [1:0] a;
        int r, f;
        v = pwm_out;
        t = (p < CMP);
        a = 2'b00;
        if (fix && v != t) a = t ? 2'b10 : 2'b01;
        #1 phase_in = W'(p); sync_act = a; sync_in = 1'b1;
        @(negedge clk);
        prev = pwm_out;
        #1 sync_in = 1'b0; sync_act = 2'b00;
        r = 0; f = 0;
        repeat (99) begin
            @(negedge clk);
            if (!prev && pwm_out) r++;
            if (prev && !pwm_out) f++;
            prev = pwm_out;
        end
        if (judge) begin
            chk(tag, r, exp_r, "rising edges in sync interval");
            chk(tag, f, 1, "falling edges in sync interval");
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    localparam int STEPS [11] = '{48, 5, 70, 5, 48, 90, 3, 60, 47, 2, 48};

    initial begin
        // reset state, R1
        repeat (4) @(negedge clk);
        chk("R1", int'(count_out), 0, "count in reset");
        chk("R1", int'(pwm_out), 0, "pwm in reset");
        chk("R1", int'(sync_out), 0, "sync_out in reset");
        #1 rst = 1'b0;
        chk_on = 1'b1;

        // master mode: wrap, sync out, sync input ignored
        cur_req = "R9";
        wait_cnt(99);
        @(negedge clk);
        chk("R1", int'(count_out), 0, "wrap after terminal count");
        chk("R9", int'(sync_out), 1, "master sync pulse at zero");
        @(negedge clk);
        chk("R9", int'(sync_out), 0, "master sync pulse one clock");
        wait_cnt(20);
        #1 sync_in = 1'b1; phase_in = W'(70);
        @(negedge clk);
        chk("R3", int'(count_out), 21, "master ignores sync");
        #1 sync_in = 1'b0;
        wait_cnt(99);
        @(negedge clk);
        chk("R2", int'(pwm_out), 1, "set at zero");
        wait_cnt(50);
        chk("R2", int'(pwm_out), 0, "clear at compare");

        // slave mode: pass-through and phase load
        cur_req = "R3";
        #1 phase_en = 1'b1; sync_in = 1'b1; phase_in = W'(30);
        #1 chk("R9", int'(sync_out), 1, "slave passes sync high");
        @(negedge clk);
        chk("R3", int'(count_out), 30, "phase loaded on sync");
        #1 sync_in = 1'b0;
        #1 chk("R9", int'(sync_out), 0, "slave passes sync low");

        // table of sync coincidences
        cur_req = "R4";
        for (int i = 0; i < NVEC; i++) begin
            wait_cnt(int'(VEC[i][18:11]));
            #1 phase_in = W'(VEC[i][10:3]); sync_act = VEC[i][2:1]; sync_in = 1'b1;
            @(negedge clk);
            chk(vtag(i), int'(pwm_out), int'(VEC[i][0]), "output after sync");
            #1 sync_in = 1'b0; sync_act = 2'b00;
        end

        // shadowed and immediate compare, R6
        cur_req = "R6";
        wait_cnt(0);
        wait_cnt(20);
        #1 cmp_in = W'(30);
        wait_cnt(31);
        chk("R6", int'(pwm_out), 1, "shadow holds old compare");
        wait_cnt(31);
        chk("R6", int'(pwm_out), 0, "shadow value active after zero");
        wait_cnt(10);
        #1 cmp_imm = 1'b1; cmp_in = W'(20);
        wait_cnt(25);
        chk("R6", int'(pwm_out), 0, "immediate compare used this period");
        #1 cmp_in = W'(CMP);
        @(negedge clk);
        #1 cmp_imm = 1'b0;
        wait_cnt(0);

        // software force priority, R8
        cur_req = "R8";
        wait_cnt(49);
        #1 force_req = 1'b1; force_act = 2'b10;
        @(negedge clk);
        chk("R8", int'(pwm_out), 1, "force beats compare");
        #1 force_req = 1'b0;
        wait_cnt(60);
        #1 force_req = 1'b1; force_act = 2'b10; sync_in = 1'b1; phase_in = W'(10); sync_act = 2'b01;
        @(negedge clk);
        chk("R8", int'(pwm_out), 1, "force beats sync action");
        #1 force_req = 1'b0; sync_in = 1'b0; sync_act = 2'b00;
        wait_cnt(99);
        #1 force_req = 1'b1; force_act = 2'b01;
        @(negedge clk);
        chk("R8", int'(pwm_out), 0, "force beats zero match");
        #1 force_req = 1'b0; force_act = 2'b00;

        // phase steps with recovery, R10
        cur_req = "R10";
        @(negedge clk);
        for (int k = 0; k < 11; k++)
            step_iv(STEPS[k], 1'b1, (k != 0), 1, "R10");
        step_iv(2, 1'b1, 1'b1, 1, "R10");
        step_iv(70, 1'b0, 1'b1, 0, "R4");
        step_iv(48, 1'b1, 1'b0, 1, "R10");
        step_iv(5, 1'b1, 1'b1, 1, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule